// File: doc/BRIEF.md
# Host Remote DMA Engine

This block moves data between a host-facing data port and the controller's local buffer memory. The host programs a 16-bit memory address and a 16-bit byte count through byte-wide register writes, then issues a 3-bit command. The command starts a read from memory to the host, a write from the host to memory, or a send-frame transfer, or it aborts the operation in progress. During a transfer, each data-port beat moves one byte or one 16-bit word. The host sees the live address and count on dedicated outputs. A completion flag, gated by a mask bit, drives the interrupt output.

Send-frame reads memory like a remote read, except that the address wraps from the receive ring's stop page back to its first page. With auto mode set, send-frame does not use the programmed address and count. It fetches a header from the page held in the boundary register, reads the count and the next-page value from that header, transfers the whole frame (header included) to the host, and then advances the boundary register to the next page on its own.

Top module: `rdma_top`

## Requirements
- R1: A command write with value 001 starts a read, 010 starts a write and 011 starts a send-frame. A value of 000 is ignored. Non-abort commands are ignored while `busy_o` is high. `busy_o` is high from the cycle after a start until the transfer ends.
- R2: Register address 0/1 loads the low/high byte of the address and 2/3 the low/high byte of the count. Writes to these registers are ignored while busy. `cur_addr_o` and `cur_cnt_o` show the live values at all times.
- R3: Each beat advances the address by 1 in byte mode and by 2 in word mode, and lowers the count by the same amount, saturating at 0. The transfer ends when the count reaches 0. A start with a count of 0 completes with no beats.
- R4: A read presents memory data on `hd_rdata_o` in ascending address order, one beat per `hd_rvalid_o`/`hd_rready_i` handshake. In byte mode the data is in bits [7:0] and bits [15:8] are 0.
- R5: A write stores each `hd_wdata_i` beat taken on `hd_wvalid_i`/`hd_wready_o`. Byte mode stores bits [7:0] at the address only.
- R6: Configuration register 4 holds word mode in bit 0, byte swap in bit 1 and auto mode in bit 2. In word mode, host bits [7:0] map to the even address and [15:8] to the odd address, and byte swap exchanges the two.
- R7: A command with bit 2 set ends any transfer in the same cycle. It leaves the address and count where they stopped and does not set the completion flag.
- R8: Completion sets `done_o`. `irq_o` is `done_o` AND bit 0 of register 5. Writing 1 to bit 0 of register 9 clears `done_o`.
- R9: During send-frame, an address that steps onto the start of the stop page (register 7) jumps to the start of the first page (register 6).
- R10: Send-frame in auto mode reads the header at the start of the boundary page (register 8, shown on `bnry_o`). Header byte 1 is the next page and bytes 2-3 are the little-endian count. The engine then transfers that count from the page start and sets the boundary to the next page on completion.
- R11: `mem_word_o` marks 16-bit memory accesses, with the even-address byte on data bits [7:0]. Read data is returned one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 3 | Command code |
| hd_wvalid_i | input | 1 | Host write data valid |
| hd_wdata_i | input | 16 | Host write data |
| hd_wready_o | output | 1 | Engine accepts write data |
| hd_rvalid_o | output | 1 | Read data valid |
| hd_rdata_o | output | 16 | Read data to host |
| hd_rready_i | input | 1 | Host accepts read data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write |
| mem_word_o | output | 1 | 16-bit access |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data, one cycle after request |
| cur_addr_o | output | 16 | Live address |
| cur_cnt_o | output | 16 | Live remaining count |
| bnry_o | output | 8 | Boundary page |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion flag |
| irq_o | output | 1 | Masked completion interrupt |

## Verification
Reads are tried in byte mode, word mode, word mode with swap at an odd address, and word mode with an odd count. Together these separate the step size, the lane placement, the swap and the count saturation. Writes in all three lane modes show whether a byte-mode write touches the neighbouring byte. Send-frame is run across the stop page in byte and word mode, which exposes a missing or misplaced wrap. Auto mode with a planted header tells a header-derived count apart from the programmed one and shows the boundary advance.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [3:0] RA_ADDR_LO = 4'd0;
  localparam logic [3:0] RA_ADDR_HI = 4'd1;
  localparam logic [3:0] RA_CNT_LO  = 4'd2;
  localparam logic [3:0] RA_CNT_HI  = 4'd3;
  localparam logic [3:0] RA_CFG     = 4'd4;
  localparam logic [3:0] RA_MASK    = 4'd5;
  localparam logic [3:0] RA_FIRST   = 4'd6;
  localparam logic [3:0] RA_STOP    = 4'd7;
  localparam logic [3:0] RA_BNRY    = 4'd8;
  localparam logic [3:0] RA_CLR     = 4'd9;

  localparam logic [2:0] CMD_READ  = 3'b001;
  localparam logic [2:0] CMD_WRITE = 3'b010;
  localparam logic [2:0] CMD_SEND  = 3'b011;

  typedef struct packed {
    logic auto_en;
    logic swap;
    logic word;
  } cfg_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR0, ST_HDR0W, ST_HDR1, ST_HDR1W,
    ST_RREQ, ST_RWAIT, ST_ROUT, ST_WR, ST_FIN
  } st_e;
endpackage

// File: rtl/rdma_cfg.sv
module rdma_cfg
  import rdma_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic          done_set_i,
  output cfg_t          cfg_o,
  output logic [PW-1:0] first_pg_o,
  output logic [PW-1:0] stop_pg_o,
  output logic          done_o,
  output logic          irq_o
);
  logic mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o      <= '0;
      mask_q     <= 1'b0;
      first_pg_o <= '0;
      stop_pg_o  <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        RA_CFG:   cfg_o      <= reg_wdata_i[2:0];
        RA_MASK:  mask_q     <= reg_wdata_i[0];
        RA_FIRST: first_pg_o <= PW'(reg_wdata_i);
        RA_STOP:  stop_pg_o  <= PW'(reg_wdata_i);
        default: ;
      endcase
    end
  end

  // set wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else if (done_set_i) done_o <= 1'b1;
    else if (reg_we_i && reg_addr_i == RA_CLR && reg_wdata_i[0]) done_o <= 1'b0;
  end

  assign irq_o = done_o & mask_q;
endmodule

// File: rtl/rdma_step.sv
module rdma_step #(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int PW = AW - 8
) (
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          word_i,
  input  logic          wrap_i,
  input  logic [PW-1:0] first_pg_i,
  input  logic [PW-1:0] stop_pg_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o
);
  logic [1:0]    inc;
  logic [AW-1:0] sum;
  logic          wrap_hit;

  always_comb begin
    inc      = word_i ? 2'd2 : 2'd1;
    sum      = addr_i + AW'(inc);
    wrap_hit = wrap_i && (sum[AW-1:8] == stop_pg_i) && (sum[7:0] == 8'h00);
    addr_o   = wrap_hit ? {first_pg_i, 8'h00} : sum;
    cnt_o    = (cnt_i <= CW'(inc)) ? '0 : cnt_i - CW'(inc);
  end
endmodule

// File: rtl/rdma_core.sv
module rdma_core
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int PW = AW - 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic          cmd_we_i,
  input  logic [2:0]    cmd_i,
  input  cfg_t          cfg_i,
  input  logic [PW-1:0] first_pg_i,
  input  logic [PW-1:0] stop_pg_i,
  input  logic          hd_wvalid_i,
  input  logic [15:0]   hd_wdata_i,
  output logic          hd_wready_o,
  output logic          hd_rvalid_o,
  output logic [15:0]   hd_rdata_o,
  input  logic          hd_rready_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_word_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic [PW-1:0] bnry_o,
  output logic          busy_o,
  output logic          done_set_o
);
  st_e           st_q;
  logic [AW-1:0] addr_q, nxt_addr;
  logic [CW-1:0] cnt_q, nxt_cnt;
  logic [PW-1:0] bnry_q, nxt_pg_q;
  logic [15:0]   rbuf_q;
  logic          send_q, auto_q;
  logic          abort_now, start_ok, wr_fire, rd_fire, hdr_st;

  rdma_step #(.AW(AW), .CW(CW)) u_step (
    .addr_i(addr_q), .cnt_i(cnt_q), .word_i(cfg_i.word), .wrap_i(send_q),
    .first_pg_i(first_pg_i), .stop_pg_i(stop_pg_i),
    .addr_o(nxt_addr), .cnt_o(nxt_cnt)
  );

  always_comb begin
    abort_now   = cmd_we_i && cmd_i[2];
    start_ok    = cmd_we_i && !cmd_i[2] && (cmd_i != 3'b000) && (st_q == ST_IDLE);
    hdr_st      = (st_q == ST_HDR0) || (st_q == ST_HDR1);
    hd_wready_o = (st_q == ST_WR) && !abort_now;
    hd_rvalid_o = (st_q == ST_ROUT) && !abort_now;
    wr_fire     = hd_wready_o && hd_wvalid_i;
    rd_fire     = hd_rvalid_o && hd_rready_i;
    mem_req_o   = !abort_now && (hdr_st || st_q == ST_RREQ || wr_fire);
    mem_we_o    = (st_q == ST_WR);
    mem_word_o  = hdr_st || cfg_i.word;
    case (st_q)
      ST_HDR0: mem_addr_o = {bnry_q, 8'h00};
      ST_HDR1: mem_addr_o = {bnry_q, 8'h02};
      default: mem_addr_o = addr_q;
    endcase
    if (!cfg_i.word)     mem_wdata_o = {8'h00, hd_wdata_i[7:0]};
    else if (cfg_i.swap) mem_wdata_o = {hd_wdata_i[7:0], hd_wdata_i[15:8]};
    else                 mem_wdata_o = hd_wdata_i;
    if (!cfg_i.word)     hd_rdata_o = {8'h00, rbuf_q[7:0]};
    else if (cfg_i.swap) hd_rdata_o = {rbuf_q[7:0], rbuf_q[15:8]};
    else                 hd_rdata_o = rbuf_q;
    busy_o     = (st_q != ST_IDLE);
    done_set_o = (st_q == ST_FIN) && !abort_now;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      cnt_q    <= '0;
      bnry_q   <= '0;
      nxt_pg_q <= '0;
      rbuf_q   <= '0;
      send_q   <= 1'b0;
      auto_q   <= 1'b0;
    end else if (abort_now) begin
      st_q <= ST_IDLE;  // address and count stay where they stopped
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (reg_we_i && !start_ok) begin
            case (reg_addr_i)
              RA_ADDR_LO: addr_q[7:0]    <= reg_wdata_i;
              RA_ADDR_HI: addr_q[AW-1:8] <= PW'(reg_wdata_i);
              RA_CNT_LO:  cnt_q[7:0]     <= reg_wdata_i;
              RA_CNT_HI:  cnt_q[CW-1:8]  <= (CW-8)'(reg_wdata_i);
              RA_BNRY:    bnry_q         <= PW'(reg_wdata_i);
              default: ;
            endcase
          end
          if (start_ok) begin
            send_q <= (cmd_i == CMD_SEND);
            auto_q <= (cmd_i == CMD_SEND) && cfg_i.auto_en;
            if (cmd_i == CMD_SEND && cfg_i.auto_en) st_q <= ST_HDR0;
            else if (cnt_q == '0)                   st_q <= ST_FIN;
            else if (cmd_i == CMD_WRITE)            st_q <= ST_WR;
            else                                    st_q <= ST_RREQ;
          end
        end
        ST_HDR0:  st_q <= ST_HDR0W;
        ST_HDR0W: begin
          nxt_pg_q <= PW'(mem_rdata_i[15:8]);
          st_q     <= ST_HDR1;
        end
        ST_HDR1:  st_q <= ST_HDR1W;
        ST_HDR1W: begin
          cnt_q  <= CW'(mem_rdata_i);
          addr_q <= {bnry_q, 8'h00};
          st_q   <= (mem_rdata_i == 16'h0) ? ST_FIN : ST_RREQ;
        end
        ST_RREQ:  st_q <= ST_RWAIT;
        ST_RWAIT: begin
          rbuf_q <= mem_rdata_i;
          st_q   <= ST_ROUT;
        end
        ST_ROUT: if (rd_fire) begin
          addr_q <= nxt_addr;
          cnt_q  <= nxt_cnt;
          st_q   <= (nxt_cnt == '0) ? ST_FIN : ST_RREQ;
        end
        ST_WR: if (wr_fire) begin
          addr_q <= nxt_addr;
          cnt_q  <= nxt_cnt;
          st_q   <= (nxt_cnt == '0) ? ST_FIN : ST_WR;
        end
        ST_FIN: begin
          if (auto_q) bnry_q <= nxt_pg_q;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cur_addr_o = addr_q;
  assign cur_cnt_o  = cnt_q;
  assign bnry_o     = bnry_q;
endmodule

// File: rtl/rdma_top.sv
module rdma_top
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int PW = AW - 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic          cmd_we_i,
  input  logic [2:0]    cmd_i,
  input  logic          hd_wvalid_i,
  input  logic [15:0]   hd_wdata_i,
  output logic          hd_wready_o,
  output logic          hd_rvalid_o,
  output logic [15:0]   hd_rdata_o,
  input  logic          hd_rready_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_word_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [15:0]   mem_wdata_o,
  input  logic [15:0]   mem_rdata_i,
  output logic [AW-1:0] cur_addr_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic [PW-1:0] bnry_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          irq_o
);
  cfg_t          cfg;
  logic [PW-1:0] first_pg, stop_pg;
  logic          done_set;

  rdma_cfg #(.PW(PW)) u_cfg (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .done_set_i(done_set), .cfg_o(cfg), .first_pg_o(first_pg),
    .stop_pg_o(stop_pg), .done_o, .irq_o
  );

  rdma_core #(.AW(AW), .CW(CW)) u_core (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .cmd_we_i, .cmd_i,
    .cfg_i(cfg), .first_pg_i(first_pg), .stop_pg_i(stop_pg),
    .hd_wvalid_i, .hd_wdata_i, .hd_wready_o, .hd_rvalid_o, .hd_rdata_o,
    .hd_rready_i, .mem_req_o, .mem_we_o, .mem_word_o, .mem_addr_o,
    .mem_wdata_o, .mem_rdata_i, .cur_addr_o, .cur_cnt_o, .bnry_o, .busy_o,
    .done_set_o(done_set)
  );
endmodule

// File: rtl/rdma_chk.sv
module rdma_chk #(
  parameter int AW = 16,
  parameter int CW = 16,
  localparam int PW = AW - 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic          cmd_we_i,
  input logic [2:0]    cmd_i,
  input logic          hd_wvalid_i,
  input logic          hd_wready_o,
  input logic          hd_rvalid_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] cur_addr_o,
  input logic [CW-1:0] cur_cnt_o,
  input logic [PW-1:0] bnry_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          irq_o
);
  // R8
  irq_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);
  // R7
  abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[2]) |=> !busy_o);
  // R1
  illegal_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_we_i && cmd_i == 3'b000) |=> !busy_o);
  // R5
  mem_write_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (hd_wvalid_i && hd_wready_o));
  // R4
  one_direction_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hd_rvalid_o && hd_wready_o));
  // R8
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
  // R2
  idle_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cmd_we_i && !reg_we_i) |=> ($stable(cur_addr_o) && $stable(cur_cnt_o)));
  // R10
  bnry_idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !reg_we_i) |=> $stable(bnry_o));
endmodule

bind rdma_top rdma_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_rdma_top.sv
module sim_rdma_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic        cmd_we_i = 1'b0;
  logic [2:0]  cmd_i = '0;
  logic        hd_wvalid_i = 1'b0;
  logic [15:0] hd_wdata_i = '0;
  logic        hd_wready_o, hd_rvalid_o, hd_rready_i;
  logic [15:0] hd_rdata_o;
  logic        mem_req_o, mem_we_o, mem_word_o;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic [15:0] cur_addr_o, cur_cnt_o;
  logic [7:0]  bnry_o;
  logic        busy_o, done_o, irq_o;

  int errs = 0;
  int checks = 0;

  logic [7:0] mem [0:1023];
  logic       init_q = 1'b0;
  logic       poke_en = 1'b0;
  logic [9:0] poke_a = '0;
  logic [7:0] poke_d = '0;

  initial hd_rready_i = 1'b0;
  initial mem_rdata_i = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rdma_top u0 (.*);

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37) + 11);
  endfunction

  // bench memory: fill, pokes, and the device port in one process
  always @(posedge clk_i) begin
    if (!init_q) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
      init_q <= 1'b1;
    end else begin
      if (poke_en) mem[poke_a] <= poke_d;
      if (mem_req_o && mem_we_o) begin
        mem[mem_addr_o[9:0]] <= mem_wdata_o[7:0];
        if (mem_word_o) mem[mem_addr_o[9:0] + 10'd1] <= mem_wdata_o[15:8];
      end else if (mem_req_o) begin
        mem_rdata_i <= mem_word_o ? {mem[mem_addr_o[9:0] + 10'd1], mem[mem_addr_o[9:0]]}
                                  : {8'h00, mem[mem_addr_o[9:0]]};
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic issue(input logic [2:0] c);
    cmd_we_i = 1'b1; cmd_i = c;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
  endtask

  task automatic poke(input logic [9:0] a, input logic [7:0] d);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk_i);
    poke_en = 1'b0;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] n, input logic [7:0] cfg);
    wr_reg(4'd0, a[7:0]); wr_reg(4'd1, a[15:8]);
    wr_reg(4'd2, n[7:0]); wr_reg(4'd3, n[15:8]);
    wr_reg(4'd4, cfg);
  endtask

  task automatic rd_expect(input string tag, input logic [15:0] a0, input int cnt,
                           input bit word, input bit swp, input bit wrp,
                           input logic [7:0] fp, input logic [7:0] sp,
                           output logic [15:0] a_end);
    logic [15:0] a;
    logic [9:0]  ia, ia1;
    logic [15:0] exp;
    int left;
    int guard;
    a = a0; left = cnt;
    hd_rready_i = 1'b1;
    while (left > 0) begin
      guard = 0;
      while (!hd_rvalid_o && guard < 50) begin @(negedge clk_i); guard++; end
      ia = a[9:0]; ia1 = ia + 10'd1;
      if (!word)    exp = {8'h00, mem[ia]};
      else if (swp) exp = {mem[ia], mem[ia1]};
      else          exp = {mem[ia1], mem[ia]};
      chk(tag, hd_rdata_o, exp);
      a = a + (word ? 16'd2 : 16'd1);
      if (wrp && a[7:0] == 8'h00 && a[15:8] == sp) a = {fp, 8'h00};
      left -= word ? 2 : 1;
      @(negedge clk_i);
    end
    hd_rready_i = 1'b0;
    a_end = a;
  endtask

  task automatic wr_beat(input logic [15:0] d);
    int guard;
    guard = 0;
    hd_wvalid_i = 1'b1; hd_wdata_i = d;
    while (!hd_wready_o && guard < 50) begin @(negedge clk_i); guard++; end
    @(negedge clk_i);
    hd_wvalid_i = 1'b0;
  endtask

  // {start address, count, config}
  localparam logic [39:0] VEC [4] = '{
    {16'h0010, 16'd5, 8'h00},
    {16'h0020, 16'd6, 8'h01},
    {16'h0031, 16'd4, 8'h03},
    {16'h0040, 16'd5, 8'h01}
  };

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 100000) begin @(posedge clk_i); cyc++; end
    errs++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] a_end;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2 R8 reset state
    chk("R2 reset addr", cur_addr_o, 0);
    chk("R2 reset cnt", cur_cnt_o, 0);
    chk("R1 reset busy", busy_o, 0);
    chk("R8 reset done/irq", {done_o, irq_o}, 0);

    // R3 R4 R6 R11 vector table of reads
    for (int v = 0; v < 4; v++) begin
      logic [15:0] va, vn;
      logic [7:0]  vc;
      int inc, beats;
      {va, vn, vc} = VEC[v];
      inc = vc[0] ? 2 : 1;
      beats = (int'(vn) + inc - 1) / inc;
      setup(va, vn, vc);
      issue(3'b001);
      chk("R1 busy after read cmd", busy_o, 1);
      rd_expect("R4 read data", va, int'(vn), vc[0], vc[1], 1'b0, 8'h0, 8'h0, a_end);
      @(negedge clk_i);
      chk("R3 final addr", cur_addr_o, va + 16'(beats * inc));
      chk("R3 final cnt", cur_cnt_o, 0);
      chk("R8 done set", done_o, 1);
      chk("R8 irq masked", irq_o, 0);
      wr_reg(4'd9, 8'h01);
      chk("R8 done cleared", done_o, 0);
    end

    // R5 R6 writes in three lane modes
    setup(16'h0200, 16'd4, 8'h01);
    issue(3'b010);
    wr_beat(16'hA1B2); wr_beat(16'hC3D4);
    @(negedge clk_i);
    chk("R5 word write", {mem[10'h203], mem[10'h202], mem[10'h201], mem[10'h200]}, 32'hC3D4A1B2);
    chk("R3 write final addr", cur_addr_o, 16'h0204);
    setup(16'h0210, 16'd2, 8'h03);
    issue(3'b010);
    wr_beat(16'h1234);
    @(negedge clk_i);
    chk("R6 swapped write", {mem[10'h210], mem[10'h211]}, 16'h1234);
    setup(16'h0220, 16'd1, 8'h00);
    issue(3'b010);
    wr_beat(16'hFF77);
    @(negedge clk_i);
    chk("R5 byte write", {mem[10'h221], mem[10'h220]}, {pat(16'h221), 8'h77});
    wr_reg(4'd9, 8'h01);

    // R7 abort mid read
    setup(16'h0080, 16'd10, 8'h00);
    issue(3'b001);
    rd_expect("R7 pre-abort data", 16'h0080, 2, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, a_end);
    issue(3'b100);
    chk("R7 abort idle", busy_o, 0);
    chk("R7 addr kept", cur_addr_o, 16'h0082);
    chk("R7 cnt kept", cur_cnt_o, 16'd8);
    @(negedge clk_i);
    chk("R7 no done", done_o, 0);

    // R1 illegal command ignored
    issue(3'b000);
    @(negedge clk_i);
    chk("R1 illegal ignored", {busy_o, hd_rvalid_o, hd_wready_o}, 0);
    chk("R1 illegal addr", cur_addr_o, 16'h0082);

    // R2 register write while busy ignored; R1 command while busy ignored
    setup(16'h0050, 16'd2, 8'h00);
    issue(3'b001);
    wr_reg(4'd0, 8'h00);
    issue(3'b010);
    rd_expect("R2 write-while-busy data", 16'h0050, 2, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, a_end);
    @(negedge clk_i);
    chk("R2 addr not overwritten", cur_addr_o, 16'h0052);

    // R8 mask and clear
    chk("R8 done pending", done_o, 1);
    chk("R8 irq off", irq_o, 0);
    wr_reg(4'd5, 8'h01);
    chk("R8 irq on", irq_o, 1);
    wr_reg(4'd9, 8'h01);
    chk("R8 irq cleared", {done_o, irq_o}, 0);

    // R3 zero count
    setup(16'h0060, 16'd0, 8'h00);
    issue(3'b001);
    @(negedge clk_i);
    chk("R3 zero count done", {busy_o, done_o}, 2'b01);
    chk("R3 zero count addr", cur_addr_o, 16'h0060);
    wr_reg(4'd9, 8'h01);

    // R9 send-frame wrap, byte then word
    wr_reg(4'd6, 8'h01); wr_reg(4'd7, 8'h03);
    setup(16'h02FE, 16'd4, 8'h00);
    issue(3'b011);
    rd_expect("R9 wrap byte data", 16'h02FE, 4, 1'b0, 1'b0, 1'b1, 8'h01, 8'h03, a_end);
    @(negedge clk_i);
    chk("R9 wrap byte addr", cur_addr_o, 16'h0102);
    setup(16'h02FC, 16'd6, 8'h01);
    issue(3'b011);
    rd_expect("R9 wrap word data", 16'h02FC, 6, 1'b1, 1'b0, 1'b1, 8'h01, 8'h03, a_end);
    @(negedge clk_i);
    chk("R9 wrap word addr", cur_addr_o, 16'h0102);
    wr_reg(4'd9, 8'h01);

    // R10 auto send-frame from header
    poke(10'h101, 8'h02); poke(10'h102, 8'h06); poke(10'h103, 8'h00);
    wr_reg(4'd8, 8'h01);
    setup(16'h0300, 16'd40, 8'h04);
    issue(3'b011);
    rd_expect("R10 auto data", 16'h0100, 6, 1'b0, 1'b0, 1'b1, 8'h01, 8'h03, a_end);
    @(negedge clk_i);
    chk("R10 auto addr", cur_addr_o, 16'h0106);
    chk("R10 auto cnt", cur_cnt_o, 0);
    chk("R10 boundary moved", bnry_o, 8'h02);
    chk("R10 done", done_o, 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule